// File: doc/BRIEF.md
# Second-Tick Prescaler with One-Shot Trim

This block divides a 32.768 kHz oscillator clock down to a one-pulse-per-second tick. Software corrects crystal frequency error by writing a signed 7-bit trim code through a simple write port. Each accepted write alters the length of exactly one later second and then reports completion. Software repeats the write every n seconds, which spreads the correction over that cycle. One trim step is 1/256 s per cycle. With n = 4096 s this is close to 1 ppm per step, and the codes span roughly -61 ppm to +60 ppm.

An accepted write raises a busy flag. The second that begins at the first tick after the write is then shortened or lengthened by the trim code times a fixed step of oscillator cycles. At the tick that closes the trimmed second, busy drops and a one-cycle completion pulse is given. A zero code needs no altered second, so it completes at the first tick after the write. The divider keeps running whenever its clock runs, including through low-power states that leave the oscillator enabled. All outputs come straight from registers.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: With no trim in progress, tick_o is a one-cycle pulse and rises every NOM_CYC clock cycles (32768 by default). The first tick comes NOM_CYC cycles after reset is released.
- R2: A write (wr_en high at a rising edge) while busy_o is low is accepted, and busy_o is high from the next cycle.
- R3: The trim code wr_trim is 7-bit two's complement (0x00..0x3F = 0..63, 0x40..0x7F = -64..-1). The second that begins at the first tick after acceptance lasts NOM_CYC - code*LSB_CYC cycles (LSB_CYC = 128 by default). A positive code shortens that second and a negative code lengthens it.
- R4: Every second after the trimmed one has the nominal length NOM_CYC.
- R5: The tick that ends the trimmed second comes with a one-cycle done_o pulse, and busy_o is low in that same cycle.
- R6: A code of 0x00 leaves every period nominal. It completes at the first tick after acceptance, with done_o pulsed and busy_o dropped in that cycle.
- R7: A write while busy_o is high is ignored. The pending code and the timing of the trim in progress do not change.
- R8: The extreme codes 0x40 (-64) and 0x3F (+63) give seconds of NOM_CYC + 64*LSB_CYC and NOM_CYC - 63*LSB_CYC cycles.
- R9: A synchronous active-high rst clears the divider, the busy flag and any pending trim. tick_o, done_o and busy_o are low while rst is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (32.768 kHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Trim register write strobe |
| wr_trim | input | TRIM_W (7) | Signed trim code, two's complement |
| busy_o | output | 1 | Trim accepted and not yet finished |
| done_o | output | 1 | One-cycle trim-complete pulse |
| tick_o | output | 1 | One-cycle second tick |

## Verification
A tick shows one cycle after the edge at which the divider reaches its terminal count. busy_o follows an accepted write by one cycle, and done_o together with the fall of busy_o lands in the same cycle as the closing tick. The bench samples every output 1 ns after each rising edge. Each cycle it updates a model built from the requirements, using the write strobe and busy state seen just before that edge, and compares tick intervals, busy and done in exactly the cycle they are due. Random write times and codes are mixed with directed extreme codes, a zero code, writes during busy and a reset in mid-trim.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_WAIT  = 2'd1,
    TS_APPLY = 2'd2
  } trim_state_t;
endpackage

// File: rtl/sec_divider.sv
module sec_divider #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] last_cnt,
  output logic             boundary,
  output logic             tick_q
);
  logic [CNT_W-1:0] cnt;

  // terminal count reached: this edge ends the current second
  assign boundary = (cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= boundary;
      cnt    <= boundary ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import rtc_trim_pkg::*;
#(
  parameter int TRIM_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [TRIM_W-1:0] wr_trim,
  input  logic              boundary,
  output logic              busy_q,
  output logic              done_q,
  output logic              apply,
  output logic [TRIM_W-1:0] trim_q
);
  trim_state_t st;

  assign apply = (st == TS_APPLY);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TS_IDLE;
      trim_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        TS_IDLE: begin
          if (wr_en) begin
            trim_q <= wr_trim;
            busy_q <= 1'b1;
            st     <= TS_WAIT;
          end
        end
        TS_WAIT: begin
          if (boundary) begin
            if (trim_q == '0) begin
              st     <= TS_IDLE;
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              st <= TS_APPLY;
            end
          end
        end
        TS_APPLY: begin
          if (boundary) begin
            st     <= TS_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
        default: st <= TS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/period_calc.sv
module period_calc #(
  parameter int NOM_CYC = 32768,
  parameter int LSB_CYC = 128,
  parameter int TRIM_W  = 7,
  parameter int CNT_W   = 16
) (
  input  logic              apply,
  input  logic [TRIM_W-1:0] trim_q,
  output logic [CNT_W-1:0]  last_cnt
);
  int code;
  int len;

  always_comb begin
    code = int'($signed(trim_q));
    len  = apply ? (NOM_CYC - code * LSB_CYC) : NOM_CYC;
    last_cnt = CNT_W'(len - 1);
  end
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler #(
  parameter int NOM_CYC = 32768,
  parameter int LSB_CYC = 128,
  parameter int TRIM_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [TRIM_W-1:0] wr_trim,
  output logic              busy_o,
  output logic              done_o,
  output logic              tick_o
);
  localparam int MAX_LEN = NOM_CYC + (2 ** (TRIM_W - 1)) * LSB_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN);

  logic              boundary;
  logic              apply;
  logic [TRIM_W-1:0] trim_q;
  logic [CNT_W-1:0]  last_cnt;

  trim_ctrl #(.TRIM_W(TRIM_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_trim(wr_trim),
    .boundary(boundary), .busy_q(busy_o), .done_q(done_o),
    .apply(apply), .trim_q(trim_q)
  );

  period_calc #(
    .NOM_CYC(NOM_CYC), .LSB_CYC(LSB_CYC), .TRIM_W(TRIM_W), .CNT_W(CNT_W)
  ) u_period (
    .apply(apply), .trim_q(trim_q), .last_cnt(last_cnt)
  );

  sec_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .last_cnt(last_cnt),
    .boundary(boundary), .tick_q(tick_o)
  );
endmodule

// File: rtl/rtc_trim_chk.sv
module rtc_trim_chk #(
  parameter int NOM_CYC = 32768,
  parameter int LSB_CYC = 128,
  parameter int TRIM_W  = 7
) (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic busy_o,
  input logic done_o,
  input logic tick_o
);
  localparam int MAX_LEN = NOM_CYC + (2 ** (TRIM_W - 1)) * LSB_CYC;

  int gap;
  always_ff @(posedge clk) begin
    if (rst || tick_o) gap <= 0;
    else               gap <= gap + 1;
  end

  AST_DONE_WITH_TICK: assert property (@(posedge clk) disable iff (rst) done_o |-> tick_o); // R5
  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst) done_o |-> $fell(busy_o)); // R5
  AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (rst) (wr_en && !busy_o) |=> busy_o); // R2
  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (rst) $rose(busy_o) |-> $past(wr_en)); // R7
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) tick_o |=> !tick_o); // R1
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst) gap <= MAX_LEN); // R3
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!busy_o && !done_o && !tick_o)); // R9
endmodule

bind rtc_trim_prescaler rtc_trim_chk #(
  .NOM_CYC(NOM_CYC), .LSB_CYC(LSB_CYC), .TRIM_W(TRIM_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en),
  .busy_o(busy_o), .done_o(done_o), .tick_o(tick_o)
);

// File: tb/tb_rtc_trim_prescaler.sv
`timescale 1ns/1ps
module tb_rtc_trim_prescaler;
  localparam int NOM = 256;
  localparam int LSB = 2;
  localparam int TW  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [TW-1:0] wr_trim = '0;
  logic busy_o, done_o, tick_o;

  int checks = 0;
  int fails  = 0;
  int m_ph   = 0;     // 0 idle, 1 waiting for tick, 2 trimmed second running
  logic [TW-1:0] m_trim = '0;
  logic m_busy = 1'b0;
  logic m_ign  = 1'b0;
  logic m_after = 1'b0;
  int gap = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rtc_trim_prescaler #(.NOM_CYC(NOM), .LSB_CYC(LSB), .TRIM_W(TW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_trim(wr_trim),
    .busy_o(busy_o), .done_o(done_o), .tick_o(tick_o)
  );

  function automatic int tlen(logic [TW-1:0] t);
    return NOM - int'($signed(t)) * LSB;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    logic r, acc, ign, e_done;
    logic [TW-1:0] wt;
    int exp_len;
    string lbl;
    r   = rst;
    acc = wr_en && !m_busy;
    ign = wr_en && m_busy;
    wt  = wr_trim;
    @(posedge clk); #1;
    if (r) begin
      m_ph = 0; m_busy = 0; gap = 0; m_ign = 0; m_after = 0;
      chk("R9 tick", tick_o, 0);
      chk("R9 busy", busy_o, 0);
      chk("R9 done", done_o, 0);
      return;
    end
    gap++;
    e_done = 0;
    if (m_ph == 2) begin
      exp_len = tlen(m_trim);
      if (m_ign) lbl = "R7 trimmed length";
      else if (m_trim == 7'h40 || m_trim == 7'h3F) lbl = "R8 trimmed length";
      else lbl = "R3 trimmed length";
    end else begin
      exp_len = NOM;
      lbl = m_after ? "R4 nominal after trim" : (m_ph == 1 && m_trim == 0 ? "R6 zero trim length" : "R1 nominal length");
    end
    if (tick_o) begin
      chk(lbl, gap, exp_len);
      gap = 0;
      m_after = 0;
      if (m_ph == 2) begin e_done = 1; m_ph = 0; m_after = 1; end
      else if (m_ph == 1) begin
        if (m_trim == 0) begin e_done = 1; m_ph = 0; end
        else m_ph = 2;
      end
    end else if (gap >= exp_len) begin
      chk({lbl, " missing tick"}, gap, exp_len - 1);
      gap = 0;
    end
    if (acc) begin m_ph = 1; m_trim = wt; m_ign = 0; end
    else if (ign) m_ign = 1;
    m_busy = (m_ph != 0);
    chk(m_trim == 0 ? "R6 done" : "R5 done", done_o, e_done);
    chk(acc ? "R2 busy" : "R7 busy", busy_o, m_busy);
  endtask

  task automatic wr(logic [TW-1:0] v);
    wr_en = 1'b1; wr_trim = v;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) cyc();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    run(3);
    rst = 1'b0;
    run(NOM + 20);                 // R1 nominal seconds
    wr(7'h40); wait_idle(); run(NOM + 5);   // R8 longest second, R4 after
    wr(7'h3F); run(3); wr(7'h05); run(40); wr(7'h7F);  // R8 shortest, R7 ignored writes
    wait_idle(); run(NOM + 5);
    wr(7'h00); wait_idle(); run(10);        // R6 zero code
    wr(7'h01); wait_idle();                 // R3 small positive
    wr(7'h7E); run(NOM / 2);                // R9 reset during pending trim
    rst = 1'b1; run(2); rst = 1'b0;
    run(NOM + 5);
    for (int k = 0; k < 40000; k++) begin
      if ($urandom_range(0, 99) < 2) wr(TW'($urandom_range(0, 127)));
      else cyc();
    end
    wait_idle(); run(NOM + 5);
    finish_up();
  end
endmodule